// File: doc/BRIEF.md
# Accuracy-Selectable Approximate Adder

This block adds two unsigned operands and a carry-in through a chain of configurable one-bit cells. Each cell works either as an exact full adder or as a cheaper approximate cell. In the approximate cell the carry is the AND of the two operand bits and ignores the incoming carry. The sum is the OR of the operand XOR and the incoming carry. A two-bit accuracy code is supplied with each addition. It chooses how many of the most significant bit positions use exact cells. All the positions below that exact region use approximate cells.

The code is decoded into a per-bit mask before the chain evaluates, so the chosen accuracy applies to the addition it travels with. No correction is made afterwards. The carry ripples from bit 0 upward through approximate and exact cells alike. A carry made in the approximate region therefore enters the exact region. By default the result and carry-out are registered, so they appear one clock after the operands are sampled. Reset clears them. A parameter can remove the register to make the path purely combinational.

Top module: `accsel_adder`

## Requirements
- R1: While `rst` is high at a clock edge, `sum_out` and `carry_out` are both cleared to 0 after that edge.
- R2: With `acc_code` = 2'b10, `{carry_out, sum_out}` equals the exact sum `op_a + op_b + carry_in` (WIDTH+1 bits).
- R3: The spare code 2'b11 behaves exactly like 2'b10 (full accuracy).
- R4: With `acc_code` = 2'b00, the top NARROW_EXACT positions (bits 31..24 by default) use exact cells and all lower positions use approximate cells.
- R5: With `acc_code` = 2'b01, the top HALF_EXACT positions (bits 31..16 by default) use exact cells and all lower positions use approximate cells.
- R6: In an approximate position, the carry out of the cell equals `a AND b` of that position, whatever its carry-in.
- R7: In an approximate position, the sum bit equals `(a XOR b) OR cin`. The cell differs from an exact adder only for the inputs (a,b,cin) = 011 and 101.
- R8: The carry ripples from bit 0 upward through approximate and exact cells. `carry_in` enters bit 0, and `carry_out` is the carry out of the top bit.
- R9: With the output register enabled (default), a result appears on the outputs exactly one clock edge after its operands and code are sampled. The code sampled with the operands sets the accuracy of that addition.
- R10: When no bit position has both operand bits set and `carry_in` is 0, every code gives `sum_out = op_a XOR op_b` and `carry_out = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| acc_code | input | 2 | Accuracy code: 00 narrow exact region, 01 half exact region, 10 and 11 fully exact |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Within one addition, a carry can be made inside the approximate region and cross into the exact region. Whether it propagates onward there depends on where the accuracy code puts the boundary. A change of code between additions decides the same boundary. Both are provoked with operands that make a carry just below the boundary and an exact-cell 011/101 pattern just above it, under each code in turn. Each result is compared with a bit-level model of the mixed cell chain, and with plain arithmetic for the full codes. A narrow six-bit instance is swept over every operand pair, carry-in and code, so that every boundary position meets every cell input pattern.

// File: rtl/accsel_pkg.sv
package accsel_pkg;

    typedef enum logic [1:0] {
        ACC_NARROW = 2'b00,
        ACC_HALF   = 2'b01,
        ACC_FULL   = 2'b10,
        ACC_SPARE  = 2'b11
    } acc_code_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } cell_out_t;

    // Number of exact upper positions requested by a code.
    function automatic int unsigned exact_span(
        input acc_code_e   code,
        input int unsigned width,
        input int unsigned narrow,
        input int unsigned half
    );
        case (code)
            ACC_NARROW: return narrow;
            ACC_HALF:   return half;
            default:    return width;
        endcase
    endfunction

endpackage

// File: rtl/accsel_cell.sv
module accsel_cell
    import accsel_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      cin,
    input  logic      exact,
    output cell_out_t res
);

    logic half_sum;
    logic gen;
    logic chain_hit;

    // The propagate-with-carry term is only built when the cell is exact;
    // with it gated off the cell degrades to the approximate form.
    always_comb begin
        half_sum  = a ^ b;
        gen       = a & b;
        chain_hit = exact & half_sum & cin;
        res.carry = gen | chain_hit;
        res.sum   = (half_sum | cin) & ~chain_hit;
    end

endmodule

// File: rtl/accsel_mask_gen.sv
module accsel_mask_gen
    import accsel_pkg::*;
#(
    parameter int unsigned WIDTH        = 32,
    parameter int unsigned NARROW_EXACT = 8,
    parameter int unsigned HALF_EXACT   = 16
) (
    input  acc_code_e        code,
    output logic [WIDTH-1:0] exact_mask
);

    localparam int unsigned SPAN_W = $clog2(WIDTH + 1);

    logic [SPAN_W-1:0] span;

    always_comb span = SPAN_W'(exact_span(code, WIDTH, NARROW_EXACT, HALF_EXACT));

    // Position i is exact when it lies within the top 'span' positions.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
        assign exact_mask[i] = ((32'(i) + 32'(span)) >= WIDTH);
    end

endmodule

// File: rtl/accsel_chain.sv
module accsel_chain
    import accsel_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic [WIDTH-1:0] exact_mask,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        cell_out_t co;
        accsel_cell u_cell (
            .a     (a[i]),
            .b     (b[i]),
            .cin   (carry[i]),
            .exact (exact_mask[i]),
            .res   (co)
        );
        assign sum[i]     = co.sum;
        assign carry[i+1] = co.carry;
    end

    assign cout = carry[WIDTH];

endmodule

// File: rtl/accsel_adder.sv
module accsel_adder
    import accsel_pkg::*;
#(
    parameter int unsigned WIDTH        = 32,
    parameter int unsigned NARROW_EXACT = 8,
    parameter int unsigned HALF_EXACT   = 16,
    parameter bit          OUT_REG      = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [1:0]       acc_code,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    logic [WIDTH-1:0] exact_mask;
    logic [WIDTH-1:0] raw_sum;
    logic             raw_cout;

    accsel_mask_gen #(
        .WIDTH        (WIDTH),
        .NARROW_EXACT (NARROW_EXACT),
        .HALF_EXACT   (HALF_EXACT)
    ) u_mask (
        .code       (acc_code_e'(acc_code)),
        .exact_mask (exact_mask)
    );

    accsel_chain #(
        .WIDTH (WIDTH)
    ) u_chain (
        .a          (op_a),
        .b          (op_b),
        .cin        (carry_in),
        .exact_mask (exact_mask),
        .sum        (raw_sum),
        .cout       (raw_cout)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_out   <= '0;
                carry_out <= 1'b0;
            end else begin
                sum_out   <= raw_sum;
                carry_out <= raw_cout;
            end
        end
    end else begin : g_comb
        assign sum_out   = raw_sum;
        assign carry_out = raw_cout;
    end

endmodule

// File: rtl/accsel_adder_chk.sv
module accsel_adder_chk #(
    parameter int unsigned WIDTH        = 32,
    parameter int unsigned NARROW_EXACT = 8,
    parameter int unsigned HALF_EXACT   = 16,
    parameter bit          OUT_REG      = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [1:0]       acc_code,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);

    localparam int unsigned NB = WIDTH - NARROW_EXACT;
    localparam int unsigned HB = WIDTH - HALF_EXACT;

    logic [WIDTH-1:0] ra, rb;
    logic             rcin;
    logic [1:0]       rcode;
    logic             rvalid;
    logic             rst_q;

    // Line the sampled inputs up with the output they produced.
    if (OUT_REG) begin : g_align
        always_ff @(posedge clk) begin
            ra     <= op_a;
            rb     <= op_b;
            rcin   <= carry_in;
            rcode  <= acc_code;
            rvalid <= !rst;
            rst_q  <= rst;
        end
    end else begin : g_direct
        always_comb begin
            ra     = op_a;
            rb     = op_b;
            rcin   = carry_in;
            rcode  = acc_code;
            rvalid = 1'b1;
            rst_q  = 1'b0;
        end
    end

    logic [WIDTH:0]        full_ref;
    logic [NARROW_EXACT:0] narrow_top;
    logic [HALF_EXACT:0]   half_top;

    always_comb begin
        full_ref   = {1'b0, ra} + {1'b0, rb} + {{WIDTH{1'b0}}, rcin};
        narrow_top = {1'b0, ra[WIDTH-1:NB]} + {1'b0, rb[WIDTH-1:NB]}
                   + {{NARROW_EXACT{1'b0}}, ra[NB-1] & rb[NB-1]};
        half_top   = {1'b0, ra[WIDTH-1:HB]} + {1'b0, rb[WIDTH-1:HB]}
                   + {{HALF_EXACT{1'b0}}, ra[HB-1] & rb[HB-1]};
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (sum_out == '0 && !carry_out)); // R1

    AST_FULL_EXACT: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcode == 2'b10) |-> ({carry_out, sum_out} == full_ref)); // R2

    AST_SPARE_EXACT: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcode == 2'b11) |-> ({carry_out, sum_out} == full_ref)); // R3

    AST_NARROW_TOP: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcode == 2'b00) |-> ({carry_out, sum_out[WIDTH-1:NB]} == narrow_top)); // R4

    AST_HALF_TOP: assert property (@(posedge clk) disable iff (rst)
        (rvalid && rcode == 2'b01) |-> ({carry_out, sum_out[WIDTH-1:HB]} == half_top)); // R5

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (rvalid && (ra & rb) == '0 && !rcin) |-> (sum_out == (ra ^ rb) && !carry_out)); // R10

endmodule

bind accsel_adder accsel_adder_chk #(
    .WIDTH        (WIDTH),
    .NARROW_EXACT (NARROW_EXACT),
    .HALF_EXACT   (HALF_EXACT),
    .OUT_REG      (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .acc_code  (acc_code),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/accsel_adder_bench.sv
module accsel_adder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // Default 32-bit instance
    logic [31:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0;
    logic [1:0]  acc_code = 2'b10;
    logic [31:0] sum_out;
    logic        carry_out;

    accsel_adder u_accsel_adder (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .acc_code(acc_code), .sum_out(sum_out), .carry_out(carry_out)
    );

    // Narrow instance for the exhaustive sweep
    logic [5:0] s_a = '0, s_b = '0;
    logic       s_cin = 1'b0;
    logic [1:0] s_code = 2'b10;
    logic [5:0] s_sum;
    logic       s_cout;

    accsel_adder #(.WIDTH(6), .NARROW_EXACT(2), .HALF_EXACT(4)) u_accsel_adder_small (
        .clk(clk), .rst(rst), .op_a(s_a), .op_b(s_b), .carry_in(s_cin),
        .acc_code(s_code), .sum_out(s_sum), .carry_out(s_cout)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    function automatic int exact_n(input logic [1:0] code, input int w, input int lo, input int mid);
        if (code == 2'b00) return lo;
        if (code == 2'b01) return mid;
        return w;
    endfunction

    // Bit-level model: exact cells on the top nex positions, approximate below.
    function automatic logic [32:0] model(input int w, input int nex,
                                          input logic [31:0] a, input logic [31:0] b, input logic cin);
        logic [32:0] r = '0;
        logic c = cin;
        for (int i = 0; i < w; i++) begin
            if (i >= w - nex) begin
                r[i] = a[i] ^ b[i] ^ c;
                c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            end else begin
                r[i] = (a[i] ^ b[i]) | c;
                c    = a[i] & b[i];
            end
        end
        r[w] = c;
        return r;
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic cin, input logic [1:0] code, input logic [32:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = cin; acc_code = code;
        @(negedge clk);
        check(tag, {carry_out, sum_out}, exp);
    endtask

    function automatic logic [32:0] arith(input logic [31:0] a, input logic [31:0] b, input logic cin);
        return {1'b0, a} + {1'b0, b} + {32'd0, cin};
    endfunction

    initial begin
        logic [31:0] seed = 32'h1F2E3D4C;
        repeat (3) @(negedge clk);
        check("R1 reset clears outputs", {carry_out, sum_out}, 33'd0);
        check("R1 reset clears narrow outputs", {26'd0, s_cout, s_sum}, 33'd0);
        rst = 1'b0;

        run("R2 full wraps to carry", 32'hFFFF_FFFF, 32'h1, 1'b0, 2'b10, 33'h1_0000_0000);
        run("R2 full mixed", 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 2'b10, arith(32'h1234_5678, 32'h9ABC_DEF0, 1'b1));
        run("R2 full half ripple", 32'h0000_FFFF, 32'h1, 1'b0, 2'b10, 33'h0_0001_0000);
        run("R3 spare code exact", 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 2'b11, arith(32'h1234_5678, 32'h9ABC_DEF0, 1'b1));
        run("R3 spare code wrap", 32'hFFFF_FFFF, 32'h0, 1'b1, 2'b11, 33'h1_0000_0000);
        run("R6 carry-in not propagated", 32'h00FF_FFFF, 32'h0, 1'b1, 2'b00, 33'h0_00FF_FFFF);
        run("R7 sum is xor or cin", 32'h1, 32'h0, 1'b1, 2'b01, 33'h0_0000_0001);
        run("R5 approx low breaks ripple", 32'h0000_FFFF, 32'h1, 1'b0, 2'b01, 33'h0_0000_FFFE);
        run("R4 bit23 approximate", 32'h00C0_0000, 32'h0040_0000, 1'b0, 2'b00, 33'h0_0080_0000);
        run("R5 bit23 exact", 32'h00C0_0000, 32'h0040_0000, 1'b0, 2'b01, 33'h0_0100_0000);
        run("R5 bit15 approximate", 32'h0000_C000, 32'h0000_4000, 1'b0, 2'b01, 33'h0_0000_8000);
        run("R4 bit15 approximate", 32'h0000_C000, 32'h0000_4000, 1'b0, 2'b00, 33'h0_0000_8000);
        run("R8 approx carry enters exact", 32'hFF80_0000, 32'h0080_0000, 1'b0, 2'b00, 33'h1_0000_0000);
        run("R10 disjoint operands", 32'hAAAA_5555, 32'h5555_AAAA, 1'b0, 2'b00, 33'h0_FFFF_FFFF);
        run("R10 disjoint operands half", 32'hAAAA_5555, 32'h5555_AAAA, 1'b0, 2'b01, 33'h0_FFFF_FFFF);

        // R9: one-edge latency and per-addition accuracy
        @(negedge clk);
        op_a = 32'h00C0_0000; op_b = 32'h0040_0000; carry_in = 1'b0; acc_code = 2'b10;
        @(posedge clk); #1;
        op_a = 32'h0000_C000; op_b = 32'h0000_4000; acc_code = 2'b00;
        check("R9 result after one edge", {carry_out, sum_out}, 33'h0_0100_0000);
        @(posedge clk); #1;
        check("R9 code travels with operands", {carry_out, sum_out}, 33'h0_0000_8000);

        // Pseudo-random sweep of the wide instance against the model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b;
            logic [1:0]  c;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
            c = 2'(k);
            run("R4/R5/R6/R7/R8 wide sweep", a, b, seed[7], c,
                model(32, exact_n(c, 32, 8, 16), a, b, seed[7]));
        end

        // Exhaustive sweep of the narrow instance
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        logic [32:0] exp;
                        @(negedge clk);
                        s_a = 6'(a); s_b = 6'(b); s_cin = 1'(ci); s_code = 2'(c);
                        @(negedge clk);
                        exp = model(6, exact_n(2'(c), 6, 2, 4), 32'(a), 32'(b), 1'(ci));
                        if (c >= 2)
                            check("R2/R3 narrow exhaustive", {26'd0, s_cout, s_sum}, 33'(a + b + ci));
                        else
                            check("R4/R5/R6/R7 narrow exhaustive", {26'd0, s_cout, s_sum}, exp);
                    end
                end
            end
        end

        // R1 reset in the middle of traffic
        @(negedge clk);
        op_a = 32'hDEAD_BEEF; op_b = 32'h1357_9BDF; carry_in = 1'b1; acc_code = 2'b10;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", {carry_out, sum_out}, 33'd0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule